// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the part of a floppy disk controller that the host processor talks to. It holds eight latch bits, the soft switches. Each host access sets or clears one of these bits, and the address of the access alone decides which bit and which level. A ninth state bit follows an external select pin. Some of the latch bits are phase and strobe lines that the drive multiplexer decodes. Two of them, together with an enable latch, decide which of four registers a host access reaches: the data register, the status byte, the write-handshake byte or the mode register.

Each access first updates its switch bit and then resolves the register through the updated switch set. The read byte is registered one clock after the access. A write can reach only the mode register. When the mode register is loaded, it also fixes the length of a bit cell in controller clocks. The drive multiplexer, the motor timer and the bit shifter sit outside this block. They supply the sense bit, the motor-active flag and the assembled data byte.

Top module: `fdc_regif`

## Requirements
- R1: After synchronous reset, the eight latch bits, the mode byte and the read byte are all zero, and the bit-cell length is 24.
- R2: An access at address A sets latch bit A[3:1] when A[0]=1 and clears it when A[0]=0. Only the low four address bits matter. Latch order from bit 0 is: phase 0, phase 1, phase 2, strobe, enable, drive select, Q6, Q7.
- R3: Bit 8 of the switch vector follows the select input.
- R4: A read at an odd address returns 0xFF.
- R5: A read at an even address with Q6=0 and Q7=0 after the update returns the data byte input. The enable latch does not matter.
- R6: A read at an even address with Q6=1 and Q7=0 returns the status byte: bits 4:0 are mode[4:0], bit 5 is the motor flag, bit 6 is 0 and bit 7 is the sense bit.
- R7: A read at an even address with Q7=1 and Q6=0 returns 0xDF.
- R8: A read at an even address with Q6=1 and Q7=1 returns 0xFF.
- R9: A write loads the mode byte from the write data when Q7=1, Q6=1 and enable=0 after that access's own switch update.
- R10: A write in any other switch state leaves the mode byte unchanged, including the case Q7=1, Q6=1 with enable=1.
- R11: The bit-cell length follows mode[4:3]: 00 gives 24 clocks, 01 gives 12, 10 gives 32 and 11 gives 16.
- R12: The read byte appears on the clock after a read access and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 4 | Register address; selects and drives one latch bit |
| wr_data | input | 8 | Host write data |
| sel_in | input | 1 | External select line |
| sense_in | input | 1 | Sense bit from the drive multiplexer |
| motor_in | input | 1 | Motor-active flag |
| data_in | input | 8 | Assembled byte from the bit shifter |
| rd_data | output | 8 | Registered read byte |
| sw_state | output | 9 | Latch bits 7:0 plus select in bit 8 |
| mode_q | output | 8 | Mode register |
| cell_len | output | 6 | Bit-cell length in clocks |

## Verification
Every access does two things in the same cycle: it changes a latch bit, and it resolves the register that the same latch set selects. The bench provokes this collision on purpose. It reads the status byte at an even address that clears Q7 on the way in. It loads the mode register with a write whose own address sets Q7. It also attempts a mode load on an access that leaves the enable latch set. Each result is judged against the register that the post-update switches select, never the pre-update ones. The mode byte is checked after each such write to confirm that it was loaded or left untouched.

// File: rtl/fdc_regif_pkg.sv
package fdc_regif_pkg;

    localparam int BYTE_W  = 8;
    localparam int SW_BITS = 8;
    localparam int SW_IDXW = $clog2(SW_BITS);

    typedef enum logic [SW_IDXW-1:0] {
        SW_PH0  = 3'd0,
        SW_PH1  = 3'd1,
        SW_PH2  = 3'd2,
        SW_STRB = 3'd3,
        SW_EN   = 3'd4,
        SW_DSEL = 3'd5,
        SW_Q6   = 3'd6,
        SW_Q7   = 3'd7
    } sw_idx_e;

    typedef enum logic [1:0] {
        RS_DATA   = 2'd0,
        RS_STATUS = 2'd1,
        RS_HSHAKE = 2'd2,
        RS_ONES   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic [SW_IDXW-1:0] idx;
        logic               level;
    } sw_cmd_t;

    localparam logic [BYTE_W-1:0] HSHAKE_BYTE = 8'hDF;
    localparam logic [BYTE_W-1:0] ONES_BYTE   = 8'hFF;

    function automatic sw_cmd_t decode_cmd(input logic [3:0] addr);
        sw_cmd_t c;
        c.idx   = addr[3:1];
        c.level = addr[0];
        return c;
    endfunction

    function automatic rsel_e pick_reg(input logic [SW_BITS-1:0] sw);
        case ({sw[SW_Q7], sw[SW_Q6]})
            2'b00:   return RS_DATA;
            2'b01:   return RS_STATUS;
            2'b10:   return RS_HSHAKE;
            default: return RS_ONES;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(
        input logic [BYTE_W-1:0] mode,
        input logic              motor,
        input logic              sense
    );
        return {sense, 1'b0, motor, mode[4:0]};
    endfunction

endpackage

// File: rtl/fdc_switch_bank.sv
module fdc_switch_bank
    import fdc_regif_pkg::*;
#(
    parameter int NBITS = SW_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  sw_cmd_t          cmd,
    output logic [NBITS-1:0] sw_q,
    output logic [NBITS-1:0] sw_nxt
);

    genvar g;
    generate
        for (g = 0; g < NBITS; g++) begin : g_bit
            logic hit;
            assign hit = upd && (cmd.idx == g[SW_IDXW-1:0]);
            assign sw_nxt[g] = hit ? cmd.level : sw_q[g];

            always_ff @(posedge clk) begin
                if (rst) sw_q[g] <= 1'b0;
                else     sw_q[g] <= sw_nxt[g];
            end
        end
    endgenerate

endmodule

// File: rtl/fdc_read_port.sv
module fdc_read_port
    import fdc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              odd_addr,
    input  rsel_e             rsel,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [BYTE_W-1:0] mode,
    input  logic              motor,
    input  logic              sense,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] rd_nxt;

    always_comb begin
        if (odd_addr) begin
            rd_nxt = ONES_BYTE;
        end else begin
            case (rsel)
                RS_DATA:   rd_nxt = data_in;
                RS_STATUS: rd_nxt = status_byte(mode, motor, sense);
                RS_HSHAKE: rd_nxt = HSHAKE_BYTE;
                default:   rd_nxt = ONES_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_nxt;
    end

endmodule

// File: rtl/fdc_mode_reg.sv
module fdc_mode_reg
    import fdc_regif_pkg::*;
#(
    parameter int CELL_W       = 6,
    parameter int CELL_SLOW_LO = 24,
    parameter int CELL_FAST_LO = 12,
    parameter int CELL_SLOW_HI = 32,
    parameter int CELL_FAST_HI = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode,
    output logic [CELL_W-1:0] cell_len
);

    localparam int FAST_BIT  = 3;
    localparam int CLOCK_BIT = 4;

    always_ff @(posedge clk) begin
        if (rst)       mode <= '0;
        else if (load) mode <= wdata;
    end

    always_comb begin
        case ({mode[CLOCK_BIT], mode[FAST_BIT]})
            2'b00:   cell_len = CELL_W'(CELL_SLOW_LO);
            2'b01:   cell_len = CELL_W'(CELL_FAST_LO);
            2'b10:   cell_len = CELL_W'(CELL_SLOW_HI);
            default: cell_len = CELL_W'(CELL_FAST_HI);
        endcase
    end

endmodule

// File: rtl/fdc_regif.sv
module fdc_regif
    import fdc_regif_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [3:0]         acc_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               sel_in,
    input  logic               sense_in,
    input  logic               motor_in,
    input  logic [BYTE_W-1:0]  data_in,
    output logic [BYTE_W-1:0]  rd_data,
    output logic [SW_BITS:0]   sw_state,
    output logic [BYTE_W-1:0]  mode_q,
    output logic [CELL_W-1:0]  cell_len
);

    sw_cmd_t              cmd;
    logic [SW_BITS-1:0]   sw_q;
    logic [SW_BITS-1:0]   sw_nxt;
    rsel_e                rsel;
    logic                 mode_load;

    assign cmd  = decode_cmd(acc_addr);
    assign rsel = pick_reg(sw_nxt);

    fdc_switch_bank #(.NBITS(SW_BITS)) u_sw (
        .clk    (clk),
        .rst    (rst),
        .upd    (acc_valid),
        .cmd    (cmd),
        .sw_q   (sw_q),
        .sw_nxt (sw_nxt)
    );

    fdc_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (acc_valid && !acc_write),
        .odd_addr (acc_addr[0]),
        .rsel     (rsel),
        .data_in  (data_in),
        .mode     (mode_q),
        .motor    (motor_in),
        .sense    (sense_in),
        .rd_data  (rd_data)
    );

    assign mode_load = acc_valid && acc_write && (rsel == RS_ONES) && !sw_nxt[SW_EN];

    fdc_mode_reg #(.CELL_W(CELL_W)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .load     (mode_load),
        .wdata    (wr_data),
        .mode     (mode_q),
        .cell_len (cell_len)
    );

    assign sw_state = {sel_in, sw_q};

endmodule

// File: rtl/fdc_regif_chk.sv
module fdc_regif_chk
    import fdc_regif_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [3:0]         acc_addr,
    input logic [BYTE_W-1:0]  rd_data,
    input logic [SW_BITS:0]   sw_state,
    input logic [BYTE_W-1:0]  mode_q,
    input logic [CELL_W-1:0]  cell_len
);

    p_latch_follows_addr_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> sw_state[$past(acc_addr[3:1])] == $past(acc_addr[0]));

    p_odd_read_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[0]) |=> rd_data == 8'hFF);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> $stable(rd_data));

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(mode_q));

    p_cell_legal_r11: assert property (@(posedge clk) disable iff (rst)
        cell_len == CELL_W'(12) || cell_len == CELL_W'(16) ||
        cell_len == CELL_W'(24) || cell_len == CELL_W'(32));

endmodule

bind fdc_regif fdc_regif_chk #(.CELL_W(CELL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .rd_data   (rd_data),
    .sw_state  (sw_state),
    .mode_q    (mode_q),
    .cell_len  (cell_len)
);

// File: tb/fdc_regif_tb_top.sv
module fdc_regif_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sel_in = 1'b0;
    logic       sense_in = 1'b0;
    logic       motor_in = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] rd_data;
    logic [8:0] sw_state;
    logic [7:0] mode_q;
    logic [5:0] cell_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_sw = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_regif dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .wr_data(wr_data), .sel_in(sel_in),
        .sense_in(sense_in), .motor_in(motor_in), .data_in(data_in),
        .rd_data(rd_data), .sw_state(sw_state), .mode_q(mode_q),
        .cell_len(cell_len)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; outputs sampled at the following falling edge.
    task automatic access(input logic wr, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = a;
        wr_data   = d;
        exp_sw[a[3:1]] = a[0];
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 switches", int'(sw_state), 0);
        check("R1 mode", int'(mode_q), 0);
        check("R1 read byte", int'(rd_data), 0);
        check("R1 cell length", int'(cell_len), 24);
    endtask

    task automatic t_switches;
        for (int i = 1; i < 16; i += 2) begin
            access(1'b0, 4'(i), 8'h00);
            check("R2 set latch", int'(sw_state[7:0]), int'(exp_sw));
            check("R4 odd read", int'(rd_data), 8'hFF);
        end
        access(1'b0, 4'h0, 8'h00);
        check("R8 both set", int'(rd_data), 8'hFF);
        for (int i = 2; i < 16; i += 2) access(1'b0, 4'(i), 8'h00);
        check("R2 cleared all", int'(sw_state[7:0]), 0);
    endtask

    task automatic t_select;
        @(negedge clk); sel_in = 1'b1; #1;
        check("R3 select high", int'(sw_state[8]), 1);
        sel_in = 1'b0; #1;
        check("R3 select low", int'(sw_state[8]), 0);
    endtask

    task automatic t_data;
        data_in = 8'hA5;
        access(1'b0, 4'h0, 8'h00);
        check("R5 data read", int'(rd_data), 8'hA5);
        access(1'b0, 4'h9, 8'h00);
        data_in = 8'h3C;
        access(1'b0, 4'h2, 8'h00);
        check("R5 data read enable set", int'(rd_data), 8'h3C);
        access(1'b0, 4'h8, 8'h00);
    endtask

    task automatic load_mode(input logic [7:0] m);
        access(1'b0, 4'hD, 8'h00);
        access(1'b0, 4'h8, 8'h00);
        access(1'b1, 4'hF, m);
    endtask

    task automatic t_status;
        load_mode(8'h1B);
        check("R9 mode loaded by Q7-setting write", int'(mode_q), 8'h1B);
        sense_in = 1'b1; motor_in = 1'b0;
        access(1'b0, 4'hE, 8'h00);
        check("R6 status after Q7 clear", int'(rd_data), 8'h9B);
        sense_in = 1'b0; motor_in = 1'b1;
        access(1'b0, 4'h0, 8'h00);
        check("R6 status motor", int'(rd_data), 8'h3B);
    endtask

    task automatic t_handshake;
        access(1'b0, 4'hC, 8'h00);
        access(1'b1, 4'hF, 8'h55);
        check("R10 no load with Q6 clear", int'(mode_q), 8'h1B);
        access(1'b0, 4'h0, 8'h00);
        check("R7 handshake", int'(rd_data), 8'hDF);
    endtask

    task automatic t_enable_write;
        access(1'b0, 4'hD, 8'h00);
        access(1'b0, 4'h9, 8'h00);
        access(1'b1, 4'hF, 8'h66);
        check("R10 no load with enable set", int'(mode_q), 8'h1B);
        access(1'b1, 4'h2, 8'h77);
        check("R10 no load other write", int'(mode_q), 8'h1B);
        access(1'b0, 4'h8, 8'h00);
    endtask

    task automatic t_cells;
        load_mode(8'h00); check("R11 slow low", int'(cell_len), 24);
        load_mode(8'h08); check("R11 fast low", int'(cell_len), 12);
        load_mode(8'h10); check("R11 slow high", int'(cell_len), 32);
        load_mode(8'hF8); check("R11 fast high", int'(cell_len), 16);
        check("R9 full byte stored", int'(mode_q), 8'hF8);
    endtask

    task automatic t_hold;
        logic [7:0] keep;
        keep = rd_data;
        data_in = 8'h11;
        repeat (3) @(negedge clk);
        check("R12 idle hold", int'(rd_data), int'(keep));
        access(1'b1, 4'h4, 8'h22);
        check("R12 write hold", int'(rd_data), int'(keep));
        access(1'b0, 4'hC, 8'h00);
        access(1'b0, 4'hE, 8'h00);
        check("R12 next read", int'(rd_data), 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_switches;
        t_select;
        t_data;
        t_status;
        t_handshake;
        t_enable_write;
        t_cells;
        t_hold;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule